// File: doc/BRIEF.md
# PS/2 Host Port Controller

This block is the host end of a single PS/2 link to a keyboard or a mouse. It watches the two open-drain lines (clock and data) through synchronizers and glitch filters and assembles each device frame into a one-byte receive buffer. It sends a host byte by inhibiting the clock, asserting request-to-send on the data line and then shifting the byte out on clocks supplied by the device. The lines are never driven high. The block only pulls a line low, through an output-enable per line.

Software sees four byte-wide registers, picked by a two-bit address. The registers are status (address 0), control (address 1), transmit buffer (address 2) and receive buffer (address 3). Reads are combinational. A read strobe on the receive buffer pops it. Two level interrupts, receive and transmit, are gated by control bits. Through the control register, software can pause reception by holding the clock low, keep the clock inhibited after a send, and hold the whole port in a cleared state.

Top module: `ps2_host_port`

## Requirements
- R1: After hardware reset, with both lines released, status reads 0x09, control reads 0x1A, and neither line output-enable is asserted.
- R2: Status bit map (register address 0):
  - bit 0 is the filtered clock line level.
  - bit 1 is the clock output-enable.
  - bit 2 is transmit busy.
  - bit 3 is transmit buffer empty.
  - bit 4 is receive buffer full.
  - bit 5 is frame reception in progress.
  - bit 6 is parity error.
  - bit 7 is framing error.
- R3: A device frame is received on falling clock edges, in this order:
  - a start bit of 0;
  - eight data bits, least significant bit first;
  - an odd parity bit;
  - a stop bit.

  At the end of the frame the byte appears at address 3, status bit 4 sets, and status bit 5 is high while the frame is partly received.
- R4: Output irq_rx is high exactly when the receive buffer is full and control bit 3 is set.
- R5: A wrong parity bit sets status bit 6, and a stop bit of 0 sets status bit 7. A read strobe at address 3 clears bits 4, 6 and 7 and drops irq_rx.
- R6: A frame that completes while the receive buffer is full is discarded, and the buffered byte is kept.
- R7: A write to address 2 starts a send only if the transmit buffer is empty and control bit 1 is set. Otherwise the write has no effect.
- R8: A send goes through these steps, with status bit 2 high and bit 3 low throughout:
  - the clock is held low for at least INHIBIT_TICKS cycles;
  - data is pulled low with the clock still low;
  - the clock is released;
  - on each device falling edge the host presents one bit, in the order eight data bits least significant bit first, odd parity, then a released stop bit;
  - the acknowledge is sampled on the eleventh falling edge.

  Output irq_tx is high when control bit 2 is set and the transmit buffer is empty.
- R9: If the acknowledge is not driven low, status bit 7 is set.
- R10: While control bit 4 is 0 and no send is active, the clock line is held low.
- R11: When control bit 0 is set at the end of a send, the clock stays inhibited until control bit 0 is cleared or a new send starts.
- R12: While control bit 5 is set, the following are held cleared and the clock is held low:
  - the receive buffer state;
  - both error flags;
  - the receiver;
  - the transmitter.
- R13: A clock-line low pulse shorter than FILT_LEN cycles after synchronization is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 status, 1 control, 2 transmit, 3 receive |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Read strobe; pops the receive buffer when reg_addr is 3 |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| ps2_clk_i | input | 1 | Sensed PS/2 clock line |
| ps2_dat_i | input | 1 | Sensed PS/2 data line |
| ps2_clk_oe | output | 1 | Pull the PS/2 clock line low |
| ps2_dat_oe | output | 1 | Pull the PS/2 data line low |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
Some properties are checked on every cycle:
- the filtered line levels only ever take a value that the synchronized input already held;
- the frame-done strobe is a single pulse;
- a send can only begin after a transmit-register write;
- the receiver is idle while a send is active;
- a receive pop always empties the buffer;
- data is pulled low only while the clock is still inhibited, and the clock is released for the whole shift phase.

Only the bench's scenarios can show the following:
- that bytes, parity and stop bits come out right across the whole frame;
- the inhibit length;
- the acknowledge handling;
- that writes are ignored when busy or disabled;
- the pause, hold-after-send and soft-reset modes;
- that glitches are rejected.

// File: rtl/ps2h_pkg.sv
package ps2h_pkg;
   typedef enum logic [1:0] {
      RA_STATUS = 2'd0,
      RA_CTRL   = 2'd1,
      RA_TXBUF  = 2'd2,
      RA_RXBUF  = 2'd3
   } ps2h_addr_e;

   // status bit positions
   localparam int ST_CLK_LVL  = 0;
   localparam int ST_CLK_INH  = 1;
   localparam int ST_TX_BUSY  = 2;
   localparam int ST_TX_EMPTY = 3;
   localparam int ST_RX_FULL  = 4;
   localparam int ST_RX_BUSY  = 5;
   localparam int ST_PAR_ERR  = 6;
   localparam int ST_FRM_ERR  = 7;

   // control bit positions
   localparam int CT_HOLD_INH = 0;
   localparam int CT_TX_EN    = 1;
   localparam int CT_TX_IE    = 2;
   localparam int CT_RX_IE    = 3;
   localparam int CT_RX_CLKEN = 4;
   localparam int CT_SOFT_RST = 5;
   localparam int CTRL_W      = 6;
   localparam logic [CTRL_W-1:0] CTRL_INIT = 6'b011010;

   localparam int DATA_BITS = 8;

   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_INHIB = 2'd1,
      TX_RTS   = 2'd2,
      TX_SHIFT = 2'd3
   } ps2h_tx_state_e;
endpackage

// File: rtl/ps2h_line_filter.sv
module ps2h_line_filter #(
   parameter int   FILT_LEN = 4,
   parameter logic IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic fall_o
);
   localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

   initial assert (FILT_LEN >= 1) else $error("FILT_LEN must be at least 1");

   logic [1:0] sync_q;
   logic       sync_w;
   logic       lvl_q;
   logic       lvl_d1_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= {IDLE_LVL, IDLE_LVL};
      else        sync_q <= {sync_q[0], line_i};
   end
   assign sync_w = sync_q[1];

   generate
      if (FILT_LEN <= 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= IDLE_LVL;
            else        lvl_q <= sync_w;
         end
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lvl_q <= IDLE_LVL;
               cnt_q <= '0;
            end else if (sync_w == lvl_q) begin
               cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
               lvl_q <= sync_w;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d1_q <= IDLE_LVL;
      else        lvl_d1_q <= lvl_q;
   end

   assign level_o = lvl_q;
   assign fall_o  = lvl_d1_q & ~lvl_q;

   // R13: the filtered level only moves to a value the synchronizer held
   a_r13_filter_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(sync_w)));
endmodule

// File: rtl/ps2h_rx_frame.sv
module ps2h_rx_frame
   import ps2h_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear_i,
   input  logic                 fall_i,
   input  logic                 dat_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic [DATA_BITS-1:0] byte_o,
   output logic                 par_err_o,
   output logic                 frm_err_o
);
   localparam int PW       = $clog2(DATA_BITS + 3);
   localparam int POS_PAR  = DATA_BITS + 1;
   localparam int POS_STOP = DATA_BITS + 2;

   logic [PW-1:0]        pos_q;
   logic [DATA_BITS-1:0] sr_q;
   logic                 par_q;
   logic                 done_q;
   logic                 perr_q;
   logic                 ferr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= '0;
         sr_q   <= '0;
         par_q  <= 1'b0;
         done_q <= 1'b0;
         perr_q <= 1'b0;
         ferr_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (clear_i) begin
            pos_q <= '0;
         end else if (fall_i) begin
            if (pos_q == '0) begin
               if (!dat_i) pos_q <= PW'(1);
            end else if (pos_q == PW'(POS_PAR)) begin
               par_q <= dat_i;
               pos_q <= PW'(POS_STOP);
            end else if (pos_q == PW'(POS_STOP)) begin
               done_q <= 1'b1;
               perr_q <= ~(^sr_q ^ par_q);
               ferr_q <= ~dat_i;
               pos_q  <= '0;
            end else begin
               sr_q  <= {dat_i, sr_q[DATA_BITS-1:1]};
               pos_q <= pos_q + 1'b1;
            end
         end
      end
   end

   assign busy_o    = (pos_q != '0);
   assign done_o    = done_q;
   assign byte_o    = sr_q;
   assign par_err_o = perr_q;
   assign frm_err_o = ferr_q;

   // R3: a completed frame is reported by a single-cycle strobe
   a_r3_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
endmodule

// File: rtl/ps2h_tx_frame.sv
module ps2h_tx_frame
   import ps2h_pkg::*;
#(
   parameter int INHIBIT_TICKS = 20000,
   parameter int RTS_TICKS     = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear_i,
   input  logic                 start_i,
   input  logic [DATA_BITS-1:0] byte_i,
   input  logic                 fall_i,
   input  logic                 dat_i,
   output logic                 clk_oe_o,
   output logic                 dat_oe_o,
   output logic                 busy_o,
   output logic                 done_o,
   output logic                 nack_o
);
   localparam int MAXT     = (INHIBIT_TICKS > RTS_TICKS) ? INHIBIT_TICKS : RTS_TICKS;
   localparam int CW       = $clog2(MAXT + 1);
   localparam int IW       = $clog2(DATA_BITS + 3);
   localparam int IDX_PAR  = DATA_BITS;
   localparam int IDX_STOP = DATA_BITS + 1;

   initial assert (INHIBIT_TICKS >= 1 && RTS_TICKS >= 1)
      else $error("tick counts must be at least 1");

   ps2h_tx_state_e       st_q;
   logic [CW-1:0]        cnt_q;
   logic [IW-1:0]        idx_q;
   logic [DATA_BITS-1:0] sh_q;
   logic                 par_q;
   logic                 clk_oe_q;
   logic                 dat_oe_q;
   logic                 done_q;
   logic                 nack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= TX_IDLE;
         cnt_q    <= '0;
         idx_q    <= '0;
         sh_q     <= '0;
         par_q    <= 1'b0;
         clk_oe_q <= 1'b0;
         dat_oe_q <= 1'b0;
         done_q   <= 1'b0;
         nack_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         nack_q <= 1'b0;
         if (clear_i) begin
            st_q     <= TX_IDLE;
            clk_oe_q <= 1'b0;
            dat_oe_q <= 1'b0;
         end else begin
            unique case (st_q)
               TX_IDLE: if (start_i) begin
                  sh_q     <= byte_i;
                  par_q    <= ~^byte_i;
                  cnt_q    <= '0;
                  clk_oe_q <= 1'b1;
                  st_q     <= TX_INHIB;
               end
               TX_INHIB: if (cnt_q == CW'(INHIBIT_TICKS - 1)) begin
                  cnt_q    <= '0;
                  dat_oe_q <= 1'b1;
                  st_q     <= TX_RTS;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
               TX_RTS: if (cnt_q == CW'(RTS_TICKS - 1)) begin
                  clk_oe_q <= 1'b0;
                  idx_q    <= '0;
                  st_q     <= TX_SHIFT;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
               TX_SHIFT: if (fall_i) begin
                  idx_q <= idx_q + 1'b1;
                  if (idx_q < IW'(IDX_PAR)) begin
                     dat_oe_q <= ~sh_q[idx_q[$clog2(DATA_BITS)-1:0]];
                  end else if (idx_q == IW'(IDX_PAR)) begin
                     dat_oe_q <= ~par_q;
                  end else if (idx_q == IW'(IDX_STOP)) begin
                     dat_oe_q <= 1'b0;
                  end else begin
                     done_q <= 1'b1;
                     nack_q <= dat_i;
                     st_q   <= TX_IDLE;
                  end
               end
               default: st_q <= TX_IDLE;
            endcase
         end
      end
   end

   assign clk_oe_o = clk_oe_q;
   assign dat_oe_o = dat_oe_q;
   assign busy_o   = (st_q != TX_IDLE);
   assign done_o   = done_q;
   assign nack_o   = nack_q;

   // R8: request-to-send is raised only while the clock is still inhibited
   a_r8_rts_under_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dat_oe_q) && $past(st_q) == TX_INHIB) |-> clk_oe_q);
   // R8: the clock is left to the device throughout the shift phase
   a_r8_shift_clock_released: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == TX_SHIFT) |-> !clk_oe_q);
endmodule

// File: rtl/ps2_host_port.sv
module ps2_host_port
   import ps2h_pkg::*;
#(
   parameter int FILT_LEN      = 4,
   parameter int INHIBIT_TICKS = 20000,
   parameter int RTS_TICKS     = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] reg_addr,
   input  logic       reg_wr,
   input  logic       reg_rd,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       ps2_clk_i,
   input  logic       ps2_dat_i,
   output logic       ps2_clk_oe,
   output logic       ps2_dat_oe,
   output logic       irq_rx,
   output logic       irq_tx
);
   localparam int NLINES = 2;
   localparam int L_CLK  = 0;
   localparam int L_DAT  = 1;

   logic [NLINES-1:0] raw_w, lvl_w, fall_w;
   assign raw_w[L_CLK] = ps2_clk_i;
   assign raw_w[L_DAT] = ps2_dat_i;

   genvar gi;
   generate
      for (gi = 0; gi < NLINES; gi++) begin : g_line
         ps2h_line_filter #(.FILT_LEN(FILT_LEN), .IDLE_LVL(1'b1)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_w[gi]),
            .level_o(lvl_w[gi]),
            .fall_o (fall_w[gi])
         );
      end
   endgenerate

   logic dat_fall_unused;
   assign dat_fall_unused = fall_w[L_DAT];

   logic [CTRL_W-1:0]    ctrl_q;
   logic [DATA_BITS-1:0] txbuf_q, rxbuf_q;
   logic                 rx_full_q, perr_q, ferr_q, hold_q;
   logic                 soft_rst, wr_ctrl, wr_tx, pop_rx, tx_start;
   logic                 rx_busy, rx_done, rx_perr, rx_ferr, rx_clear;
   logic [DATA_BITS-1:0] rx_byte;
   logic                 tx_busy, tx_done, tx_nack, tx_clk_oe, tx_dat_oe;
   logic [7:0]           status_w;
   logic                 ctrl_wr_unused;

   assign ctrl_wr_unused = ^reg_wdata[7:CTRL_W];
   assign soft_rst = ctrl_q[CT_SOFT_RST];
   assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
   assign wr_tx    = reg_wr && (reg_addr == RA_TXBUF);
   assign pop_rx   = reg_rd && (reg_addr == RA_RXBUF);
   assign tx_start = wr_tx && !tx_busy && ctrl_q[CT_TX_EN] && !soft_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= CTRL_INIT;
         txbuf_q <= '0;
      end else begin
         if (wr_ctrl)  ctrl_q  <= reg_wdata[CTRL_W-1:0];
         if (tx_start) txbuf_q <= reg_wdata;
      end
   end

   // the clock is pulled low by soft reset, by the sender, by a paused receiver,
   // or by the post-send hold
   assign ps2_clk_oe = soft_rst | tx_clk_oe |
                       (!tx_busy & (!ctrl_q[CT_RX_CLKEN] | hold_q)) |
                       (tx_done & ctrl_q[CT_HOLD_INH]);
   assign ps2_dat_oe = tx_dat_oe;
   assign rx_clear   = soft_rst | tx_busy | ps2_clk_oe;

   ps2h_rx_frame u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (rx_clear),
      .fall_i   (fall_w[L_CLK]),
      .dat_i    (lvl_w[L_DAT]),
      .busy_o   (rx_busy),
      .done_o   (rx_done),
      .byte_o   (rx_byte),
      .par_err_o(rx_perr),
      .frm_err_o(rx_ferr)
   );

   ps2h_tx_frame #(.INHIBIT_TICKS(INHIBIT_TICKS), .RTS_TICKS(RTS_TICKS)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (soft_rst),
      .start_i (tx_start),
      .byte_i  (reg_wdata),
      .fall_i  (fall_w[L_CLK]),
      .dat_i   (lvl_w[L_DAT]),
      .clk_oe_o(tx_clk_oe),
      .dat_oe_o(tx_dat_oe),
      .busy_o  (tx_busy),
      .done_o  (tx_done),
      .nack_o  (tx_nack)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_full_q <= 1'b0;
         rxbuf_q   <= '0;
         perr_q    <= 1'b0;
         ferr_q    <= 1'b0;
         hold_q    <= 1'b0;
      end else if (soft_rst) begin
         rx_full_q <= 1'b0;
         perr_q    <= 1'b0;
         ferr_q    <= 1'b0;
         hold_q    <= 1'b0;
      end else begin
         if (pop_rx) begin
            rx_full_q <= 1'b0;
            perr_q    <= 1'b0;
            ferr_q    <= 1'b0;
         end else begin
            if (rx_done && !rx_full_q) begin
               rx_full_q <= 1'b1;
               rxbuf_q   <= rx_byte;
               perr_q    <= rx_perr;
               ferr_q    <= rx_ferr;
            end
            if (tx_done && tx_nack) ferr_q <= 1'b1;
         end
         if (!ctrl_q[CT_HOLD_INH] || tx_start) hold_q <= 1'b0;
         else if (tx_done)                     hold_q <= 1'b1;
      end
   end

   always_comb begin
      status_w              = '0;
      status_w[ST_CLK_LVL]  = lvl_w[L_CLK];
      status_w[ST_CLK_INH]  = ps2_clk_oe;
      status_w[ST_TX_BUSY]  = tx_busy;
      status_w[ST_TX_EMPTY] = !tx_busy;
      status_w[ST_RX_FULL]  = rx_full_q;
      status_w[ST_RX_BUSY]  = rx_busy;
      status_w[ST_PAR_ERR]  = perr_q;
      status_w[ST_FRM_ERR]  = ferr_q;
   end

   always_comb begin
      unique case (reg_addr)
         RA_STATUS: reg_rdata = status_w;
         RA_CTRL:   reg_rdata = {{(8 - CTRL_W){1'b0}}, ctrl_q};
         RA_TXBUF:  reg_rdata = txbuf_q;
         default:   reg_rdata = rxbuf_q;
      endcase
   end

   assign irq_rx = ctrl_q[CT_RX_IE] & rx_full_q;
   assign irq_tx = ctrl_q[CT_TX_IE] & !tx_busy;

   // R3: the buffer only fills from a completed frame
   a_r3_full_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full_q) |-> $past(rx_done));
   // R5: a pop of the receive buffer always leaves it empty
   a_r5_pop_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == RA_RXBUF) |=> !rx_full_q);
   // R7: a send only begins after a write to the transmit register
   a_r7_send_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> $past(reg_wr && reg_addr == RA_TXBUF));
   // R8: the receiver is idle while a send is in flight
   a_r8_rx_idle_during_send: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |=> !rx_busy);
endmodule

// File: tb/ps2_host_port_tb.sv
module ps2_host_port_tb;
   localparam int FILT = 4;
   localparam int INH  = 40;
   localparam int RTS  = 8;
   localparam int HALF = 30;
   localparam int NV   = 5;
   // {bad_stop, bad_parity, data}
   localparam logic [9:0] RXV [NV] = '{10'h0A5, 10'h000, 10'h0FF, 10'h13C, 10'h281};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic ps2_clk_oe, ps2_dat_oe, irq_rx, irq_tx;
   logic dev_clk_low = 1'b0, dev_dat_low = 1'b0;
   logic clk_line, dat_line;
   int n_checks = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   assign clk_line = ~(ps2_clk_oe | dev_clk_low);
   assign dat_line = ~(ps2_dat_oe | dev_dat_low);

   ps2_host_port #(.FILT_LEN(FILT), .INHIBIT_TICKS(INH), .RTS_TICKS(RTS)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ps2_clk_i(clk_line),
      .ps2_dat_i(dat_line), .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe),
      .irq_rx(irq_rx), .irq_tx(irq_tx));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, input logic pop, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = pop;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic send_frame(input logic [7:0] b, input logic bad_par, input logic bad_stop);
      logic [10:0] bits;
      bits = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
      for (int k = 0; k < 11; k++) begin
         dev_dat_low = ~bits[k];
         wait_cyc(HALF);
         dev_clk_low = 1'b1;
         wait_cyc(HALF);
         dev_clk_low = 1'b0;
      end
      dev_dat_low = 1'b0;
      wait_cyc(2 * HALF);
   endtask

   task automatic recv_host(input logic do_ack, output logic [7:0] got,
                            output logic par, output logic stop);
      logic [9:0] s;
      while (!(ps2_dat_oe && !ps2_clk_oe)) @(negedge clk);
      wait_cyc(HALF);
      for (int k = 0; k < 10; k++) begin
         dev_clk_low = 1'b1;
         wait_cyc(HALF);
         dev_clk_low = 1'b0;
         wait_cyc(HALF / 2);
         s[k] = dat_line;
         wait_cyc(HALF / 2);
      end
      if (do_ack) dev_dat_low = 1'b1;
      wait_cyc(4);
      dev_clk_low = 1'b1;
      wait_cyc(HALF);
      dev_clk_low = 1'b0;
      wait_cyc(HALF);
      dev_dat_low = 1'b0;
      wait_cyc(4);
      got = s[7:0]; par = s[8]; stop = s[9];
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] d, got;
      logic par, stop;
      int n;
      wait_cyc(4);
      rst_n = 1'b1;
      wait_cyc(4);

      // R1 reset state
      reg_read(2'd0, 1'b0, d);  chk("R1 status after reset", d, 8'h09);
      reg_read(2'd1, 1'b0, d);  chk("R1 control after reset", d, 8'h1A);
      chk("R1 no line driven", {ps2_clk_oe, ps2_dat_oe}, 2'b00);

      // R3 R5 R2: vector table of device frames
      for (int i = 0; i < NV; i++) begin
         send_frame(RXV[i][7:0], RXV[i][8], RXV[i][9]);
         reg_read(2'd0, 1'b0, d);
         chk("R3 R5 R2 status after frame", d, 8'h19 | {RXV[i][9], RXV[i][8], 6'b0});
         chk("R4 irq_rx with buffer full", irq_rx, 1'b1);
         reg_read(2'd3, 1'b1, d);
         chk("R3 received byte", d, RXV[i][7:0]);
         reg_read(2'd0, 1'b0, d);
         chk("R5 status after pop", d, 8'h09);
         chk("R5 irq_rx after pop", irq_rx, 1'b0);
      end

      // R6 frame while full is dropped
      send_frame(8'hA1, 1'b0, 1'b0);
      send_frame(8'hB2, 1'b0, 1'b0);
      reg_read(2'd3, 1'b1, d);
      chk("R6 first byte kept", d, 8'hA1);

      // R4 interrupt gating
      reg_write(2'd1, 8'h12);
      send_frame(8'h4D, 1'b0, 1'b0);
      reg_read(2'd0, 1'b0, d);
      chk("R4 full with irq disabled", d[4], 1'b1);
      chk("R4 irq_rx masked", irq_rx, 1'b0);
      reg_write(2'd1, 8'h1A);
      wait_cyc(1);
      chk("R4 irq_rx unmasked", irq_rx, 1'b1);
      reg_read(2'd3, 1'b1, d);

      // R7 write ignored while transmit disabled
      reg_write(2'd1, 8'h18);
      reg_write(2'd2, 8'h77);
      wait_cyc(10);
      reg_read(2'd0, 1'b0, d);
      chk("R7 tx disabled, still empty", d, 8'h09);
      chk("R7 tx disabled, clock free", ps2_clk_oe, 1'b0);

      // R8 normal send
      reg_write(2'd1, 8'h1E);
      wait_cyc(1);
      chk("R8 irq_tx when empty", irq_tx, 1'b1);
      reg_write(2'd2, 8'h5A);
      n = 0;
      while (!ps2_dat_oe) begin
         if (ps2_clk_oe) n++;
         @(negedge clk);
      end
      chk("R8 inhibit length at least INH", n >= INH, 1'b1);
      reg_read(2'd0, 1'b0, d);
      chk("R8 busy and not empty", d[3:2], 2'b01);
      chk("R8 irq_tx low while busy", irq_tx, 1'b0);
      reg_write(2'd2, 8'h33);
      recv_host(1'b1, got, par, stop);
      chk("R7 R8 byte seen by device", got, 8'h5A);
      chk("R8 odd parity", ^{got, par}, 1'b1);
      chk("R8 stop released", stop, 1'b1);
      reg_read(2'd0, 1'b0, d);
      chk("R8 status after send", d, 8'h09);

      // R9 missing acknowledge
      reg_write(2'd2, 8'hC3);
      recv_host(1'b0, got, par, stop);
      chk("R9 byte", got, 8'hC3);
      reg_read(2'd0, 1'b0, d);
      chk("R9 framing flag on nack", d[7], 1'b1);
      reg_read(2'd3, 1'b1, d);
      reg_read(2'd0, 1'b0, d);
      chk("R9 flag cleared by pop", d[7], 1'b0);

      // R11 hold clock after send
      reg_write(2'd1, 8'h1B);
      reg_write(2'd2, 8'h12);
      recv_host(1'b1, got, par, stop);
      wait_cyc(4);
      chk("R11 clock held after send", ps2_clk_oe, 1'b1);
      reg_read(2'd0, 1'b0, d);
      chk("R11 inhibit status bit", d[1:0], 2'b10);
      reg_write(2'd1, 8'h1A);
      wait_cyc(12);
      chk("R11 clock released", ps2_clk_oe, 1'b0);

      // R10 pause reception
      reg_write(2'd1, 8'h0A);
      wait_cyc(12);
      chk("R10 clock held when paused", ps2_clk_oe, 1'b1);
      reg_read(2'd0, 1'b0, d);
      chk("R10 R2 status when paused", d, 8'h0A);
      reg_write(2'd1, 8'h1A);
      wait_cyc(12);

      // R13 glitch rejection, R12 soft reset
      dev_dat_low = 1'b1;
      for (int g = 0; g < 3; g++) begin
         @(negedge clk); dev_clk_low = 1'b1;
         wait_cyc(2);    dev_clk_low = 1'b0;
         wait_cyc(10);
      end
      reg_read(2'd0, 1'b0, d);
      chk("R13 short pulses ignored", d[5], 1'b0);
      dev_clk_low = 1'b1; wait_cyc(HALF);
      dev_clk_low = 1'b0; wait_cyc(HALF);
      reg_read(2'd0, 1'b0, d);
      chk("R3 reception in progress", d[5], 1'b1);
      dev_dat_low = 1'b0;
      send_frame(8'h00, 1'b0, 1'b0);
      reg_write(2'd1, 8'h3A);
      wait_cyc(2);
      reg_read(2'd0, 1'b0, d);
      chk("R12 soft reset clears port", d[7:1], 7'b0000101);
      chk("R12 clock held in soft reset", ps2_clk_oe, 1'b1);
      reg_write(2'd1, 8'h1A);
      wait_cyc(12);
      send_frame(8'h6E, 1'b0, 1'b0);
      reg_read(2'd3, 1'b1, d);
      chk("R12 clean frame after soft reset", d, 8'h6E);

      finish_run();
   end
endmodule